// File: doc/BRIEF.md
# Transmit Descriptor Ring Sequencer

The sequencer walks a power-of-two ring of transmit descriptors that a host and a DMA engine share. Each descriptor has an ownership flag plus start-of-frame and end-of-frame marks. The sequencer chooses the descriptor to read next and drives the data-fetch handshake for each owned buffer. It returns descriptors to the host by writing back ownership-cleared status words.

Buffers that are not the last of a frame are released as soon as their data has been fetched. The last buffer of a frame is held until the transmitter reports the frame as done. Fetching reads ahead past a frame's last descriptor while fewer than two frames are held. As a result, a chained buffer of the next frame can be released before the last descriptor of the frame being sent is written.

A fetch error writes both status words of the current descriptor. The sequencer then skips the rest of that frame, clearing every owned descriptor that is not a start of frame. Every frame completion runs a poll at once. The poll first checks the receive descriptor unless that descriptor is already owned, then reads the next transmit descriptor. The completion also sets a sticky transmit-interrupt bit. When nothing is pending, a poll interval timer restarts polling.

Top module: `tx_ring_seq`

## Requirements
- R1: After reset all request outputs, `tint_o` and `irq_o` are low. With nothing pending, the first receive poll starts about POLL_CYC cycles after reset is released, and the first descriptor read is at index 0.
- R2: The ring index advances by one per descriptor consumed and wraps from RING-1 to 0.
- R3: A read of a descriptor with ownership clear fetches nothing, and polling repeats no sooner than POLL_CYC cycles later. A read of an owned start-of-frame descriptor starts data fetches at that index.
- R4: When a buffer that is not end-of-frame is fully fetched (fetch acknowledged with `fetch_last_i` high), one write of word 0 with data 0 goes to its index before the next descriptor read. This also applies to a chained buffer of a following frame.
- R5: A fully fetched end-of-frame buffer gets no write until its frame is done. While fewer than MAX_FRAMES frames are held, the next descriptor is read immediately (look-ahead). With MAX_FRAMES held, no descriptor is read until a frame is done.
- R6: A `tx_done_i` pulse causes a word 0, data 0 write to the oldest held end-of-frame index. A poll then follows within 8 cycles, with no poll interval wait.
- R7: `tx_err_i` during a fetch stops fetching for that buffer. It causes a write of word 1 with data 1, then a write of word 0 with data 0, both at the current index.
- R8: After an error write-back, each following descriptor that is owned but not start-of-frame gets a word 0, data 0 write. The scan stops at a descriptor that is not owned or that is owned start-of-frame, and such a start-of-frame descriptor is then fetched.
- R9: A poll with `rx_owned_i` high raises no `rx_req_o`. With it low, `rx_req_o` is raised and held until `rx_ack_i` before the transmit descriptor read.
- R10: `tint_o` is set by each frame completion (a done write or an error write-back) and stays set until `tint_clr_i`. `irq_o` is high exactly when `tint_o` is high, `int_en_i` is high and `tint_mask_i` is low.
- R11: A pending descriptor read or write-back keeps its index and word stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_owned_i | input | 1 | Current receive descriptor already owned |
| rx_req_o | output | 1 | Receive descriptor poll request |
| rx_ack_i | input | 1 | Receive poll completed |
| rd_req_o | output | 1 | Descriptor read request |
| rd_idx_o | output | $clog2(RING) | Descriptor read index |
| rd_ack_i | input | 1 | Read response valid |
| rd_own_i | input | 1 | Read descriptor ownership flag |
| rd_stp_i | input | 1 | Read descriptor start-of-frame mark |
| rd_enp_i | input | 1 | Read descriptor end-of-frame mark |
| fetch_req_o | output | 1 | Buffer data access request |
| fetch_idx_o | output | $clog2(RING) | Descriptor whose buffer is fetched |
| fetch_ack_i | input | 1 | Data access completed |
| fetch_last_i | input | 1 | Acknowledged access was the buffer's last |
| tx_err_i | input | 1 | Transmit error during the current fetch |
| tx_done_i | input | 1 | Oldest held frame finished transmission |
| wb_valid_o | output | 1 | Status write-back request |
| wb_ready_i | input | 1 | Write-back accepted |
| wb_idx_o | output | $clog2(RING) | Write-back descriptor index |
| wb_word_o | output | 1 | 0 control word, 1 error status word |
| wb_data_o | output | 2 | Written value: 0 ownership cleared, 1 error flag |
| int_en_i | input | 1 | Global interrupt enable |
| tint_mask_i | input | 1 | Transmit interrupt mask |
| tint_clr_i | input | 1 | Clears the transmit-interrupt bit |
| tint_o | output | 1 | Transmit-interrupt status bit |
| irq_o | output | 1 | Interrupt output |

## Verification
The assertions assume single-cycle read, poll and fetch responders that answer only while a request is up. They also assume that `tx_done_i` pulses only while at least one frame is held, and that `tx_err_i` is raised only during a fetch. The bench's responders answer on the falling edge and only while the matching request is high. The bench raises the error once, on the first data access of a chosen buffer. It pulses done only after a frame's end-of-frame buffer has been fetched, and stalls the write-back port on one write only.

// File: rtl/txring_pkg.sv
package txring_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_RXPOLL, S_TXRD, S_FETCH, S_WBOWN, S_WBERR1,
    S_WBERR0, S_SKRD, S_SKWB, S_WBDONE, S_HOLD
  } seq_state_e;
  localparam logic       WORD_CTRL = 1'b0;
  localparam logic       WORD_STAT = 1'b1;
  localparam logic [1:0] DATA_REL  = 2'b00;
  localparam logic [1:0] DATA_ERR  = 2'b01;
endpackage

// File: rtl/txring_poll_timer.sv
module txring_poll_timer #(
  parameter int CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic fire_o
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
  logic [CW-1:0] cnt_q;

  assign fire_o = run_i && (cnt_q == CW'(CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || fire_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/txring_frame_q.sv
module txring_frame_q #(
  parameter int DEPTH = 2,
  parameter int IW    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [IW-1:0] push_idx_i,
  input  logic          pop_i,
  output logic [IW-1:0] head_o,
  output logic [$clog2(DEPTH):0] count_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  logic [IW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [$clog2(DEPTH):0] cnt_q;

  assign head_o  = mem_q[rp_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_i) begin
        mem_q[wp_q] <= push_idx_i;
        wp_q        <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + PW'(1);
      end
      if (pop_i) rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + PW'(1);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/txring_tint.sv
module txring_tint (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  input  logic mask_i,
  output logic tint_o,
  output logic irq_o
);
  logic tint_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tint_q <= 1'b0;
    else if (set_i)  tint_q <= 1'b1;
    else if (clr_i)  tint_q <= 1'b0;
  end
  assign tint_o = tint_q;
  assign irq_o  = tint_q && en_i && !mask_i;
endmodule

// File: rtl/tx_ring_seq.sv
module tx_ring_seq
  import txring_pkg::*;
#(
  parameter int RING       = 8,
  parameter int POLL_CYC   = 16,
  parameter int MAX_FRAMES = 2,
  localparam int IW        = (RING > 1) ? $clog2(RING) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_owned_i,
  output logic          rx_req_o,
  input  logic          rx_ack_i,
  output logic          rd_req_o,
  output logic [IW-1:0] rd_idx_o,
  input  logic          rd_ack_i,
  input  logic          rd_own_i,
  input  logic          rd_stp_i,
  input  logic          rd_enp_i,
  output logic          fetch_req_o,
  output logic [IW-1:0] fetch_idx_o,
  input  logic          fetch_ack_i,
  input  logic          fetch_last_i,
  input  logic          tx_err_i,
  input  logic          tx_done_i,
  output logic          wb_valid_o,
  input  logic          wb_ready_i,
  output logic [IW-1:0] wb_idx_o,
  output logic          wb_word_o,
  output logic [1:0]    wb_data_o,
  input  logic          int_en_i,
  input  logic          tint_mask_i,
  input  logic          tint_clr_i,
  output logic          tint_o,
  output logic          irq_o
);
  localparam int QW = $clog2(MAX_FRAMES) + 1;

  seq_state_e    state_q, state_d;
  logic [IW-1:0] cur_q;
  logic          adv;
  logic          in_frame_q, in_frame_d;
  logic          enp_q, enp_d;
  logic          done_pend_q;
  logic          poll_fire, wb_fire;
  logic          q_push, q_pop, tint_set;
  logic [IW-1:0] q_head;
  logic [QW-1:0] q_count;

  txring_poll_timer #(.CYC(POLL_CYC)) u_timer (
    .clk_i, .rst_ni, .run_i(state_q == S_IDLE && !done_pend_q), .fire_o(poll_fire)
  );

  txring_frame_q #(.DEPTH(MAX_FRAMES), .IW(IW)) u_fq (
    .clk_i, .rst_ni, .push_i(q_push), .push_idx_i(cur_q),
    .pop_i(q_pop), .head_o(q_head), .count_o(q_count)
  );

  txring_tint u_tint (
    .clk_i, .rst_ni, .set_i(tint_set), .clr_i(tint_clr_i),
    .en_i(int_en_i), .mask_i(tint_mask_i), .tint_o, .irq_o
  );

  assign rx_req_o    = (state_q == S_RXPOLL) && !rx_owned_i;
  assign rd_req_o    = (state_q == S_TXRD) || (state_q == S_SKRD);
  assign rd_idx_o    = cur_q;
  assign fetch_req_o = (state_q == S_FETCH);
  assign fetch_idx_o = cur_q;
  assign wb_valid_o  = (state_q == S_WBOWN) || (state_q == S_WBERR1) ||
                       (state_q == S_WBERR0) || (state_q == S_SKWB) ||
                       (state_q == S_WBDONE);
  assign wb_idx_o    = (state_q == S_WBDONE) ? q_head : cur_q;
  assign wb_word_o   = (state_q == S_WBERR1) ? WORD_STAT : WORD_CTRL;
  assign wb_data_o   = (state_q == S_WBERR1) ? DATA_ERR : DATA_REL;
  assign wb_fire     = wb_valid_o && wb_ready_i;

  always_comb begin
    state_d    = state_q;
    in_frame_d = in_frame_q;
    enp_d      = enp_q;
    adv        = 1'b0;
    q_push     = 1'b0;
    q_pop      = 1'b0;
    tint_set   = 1'b0;
    unique case (state_q)
      S_IDLE:   if (done_pend_q) state_d = S_WBDONE;
                else if (poll_fire) state_d = S_RXPOLL;
      S_RXPOLL: if (rx_owned_i || rx_ack_i) state_d = S_TXRD;
      S_TXRD:   if (rd_ack_i) begin
                  if (!rd_own_i) state_d = S_IDLE;
                  else if (in_frame_q || rd_stp_i) begin
                    state_d    = S_FETCH;
                    in_frame_d = 1'b1;
                    enp_d      = rd_enp_i;
                  end else state_d = S_SKWB;      // orphan chained buffer
                end
      S_FETCH:  if (tx_err_i) state_d = S_WBERR1;
                else if (fetch_ack_i && fetch_last_i) begin
                  if (enp_q) begin
                    q_push     = 1'b1;
                    adv        = 1'b1;
                    in_frame_d = 1'b0;
                    state_d    = (q_count == QW'(MAX_FRAMES - 1)) ? S_HOLD : S_TXRD;
                  end else state_d = S_WBOWN;
                end
      S_WBOWN:  if (wb_fire) begin
                  adv     = 1'b1;
                  state_d = done_pend_q ? S_WBDONE : S_TXRD;
                end
      S_WBERR1: if (wb_fire) state_d = S_WBERR0;
      S_WBERR0: if (wb_fire) begin
                  adv        = 1'b1;
                  in_frame_d = 1'b0;
                  tint_set   = 1'b1;
                  state_d    = S_SKRD;
                end
      S_SKRD:   if (rd_ack_i) state_d = (rd_own_i && !rd_stp_i) ? S_SKWB : S_RXPOLL;
      S_SKWB:   if (wb_fire) begin
                  adv     = 1'b1;
                  state_d = S_SKRD;
                end
      S_WBDONE: if (wb_fire) begin
                  q_pop    = 1'b1;
                  tint_set = 1'b1;
                  state_d  = S_RXPOLL;
                end
      S_HOLD:   if (done_pend_q) state_d = S_WBDONE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      cur_q       <= '0;
      in_frame_q  <= 1'b0;
      enp_q       <= 1'b0;
      done_pend_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      in_frame_q <= in_frame_d;
      enp_q      <= enp_d;
      if (adv) cur_q <= (cur_q == IW'(RING - 1)) ? '0 : cur_q + IW'(1);
      if (tx_done_i)  done_pend_q <= 1'b1;
      else if (q_pop) done_pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tx_ring_seq_chk.sv
module tx_ring_seq_chk #(
  parameter int IW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_owned_i,
  input logic          rx_req_o,
  input logic          rd_req_o,
  input logic [IW-1:0] rd_idx_o,
  input logic          rd_ack_i,
  input logic          fetch_req_o,
  input logic          tx_err_i,
  input logic          wb_valid_o,
  input logic          wb_ready_i,
  input logic [IW-1:0] wb_idx_o,
  input logic          wb_word_o,
  input logic [1:0]    wb_data_o,
  input logic          int_en_i,
  input logic          tint_mask_i,
  input logic          tint_clr_i,
  input logic          tint_o,
  input logic          irq_o
);
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_idx_o)); // R11
  AST_WB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o && !wb_ready_i |=> wb_valid_o && $stable(wb_idx_o) && $stable(wb_word_o)); // R11
  AST_ERR_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o && wb_ready_i && wb_word_o |=>
      wb_valid_o && !wb_word_o && wb_data_o == 2'b00 && wb_idx_o == $past(wb_idx_o)); // R7
  AST_ERR_NOFETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o && tx_err_i |=> !fetch_req_o); // R7
  AST_RX_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_owned_i |-> !rx_req_o); // R9
  AST_TINT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tint_o && !tint_clr_i |=> tint_o); // R10
  AST_IRQ_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> int_en_i && !tint_mask_i); // R10
endmodule

bind tx_ring_seq tx_ring_seq_chk #(.IW(IW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_owned_i(rx_owned_i), .rx_req_o(rx_req_o),
  .rd_req_o(rd_req_o), .rd_idx_o(rd_idx_o), .rd_ack_i(rd_ack_i),
  .fetch_req_o(fetch_req_o), .tx_err_i(tx_err_i), .wb_valid_o(wb_valid_o),
  .wb_ready_i(wb_ready_i), .wb_idx_o(wb_idx_o), .wb_word_o(wb_word_o),
  .wb_data_o(wb_data_o), .int_en_i(int_en_i), .tint_mask_i(tint_mask_i),
  .tint_clr_i(tint_clr_i), .tint_o(tint_o), .irq_o(irq_o)
);

// File: tb/tb_tx_ring_seq.sv
module tb_tx_ring_seq;
  localparam int RING = 8;
  localparam int POLL = 16;
  localparam int IW   = 3;
  localparam int LOGN = 512;
  // {int_en, mask, expected irq}
  localparam logic [2:0] IRQ_TAB [4] = '{3'b101, 3'b110, 3'b000, 3'b010};

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_owned = 1'b0, rx_req, rx_ack = 1'b0;
  logic rd_req, rd_ack = 1'b0, rd_own = 1'b0, rd_stp = 1'b0, rd_enp = 1'b0;
  logic [IW-1:0] rd_idx, fetch_idx, wb_idx;
  logic fetch_req, fetch_ack = 1'b0, fetch_last = 1'b0, tx_err = 1'b0, tx_done = 1'b0;
  logic wb_valid, wb_ready = 1'b0, wb_word;
  logic [1:0] wb_data;
  logic int_en = 1'b0, tmask = 1'b0, tclr = 1'b0, tint, irq;

  int set_gen [RING];
  int clr_gen [RING];
  logic stp_m [RING];
  logic enp_m [RING];
  int ev_k [LOGN], ev_i [LOGN], ev_w [LOGN], ev_d [LOGN], ev_c [LOGN];
  int n_ev = 0, cyc = 0, beat = 0;
  int stall_req = 0, stall_used = 0, err_req = 0, err_used = 0, err_idx = 5;
  logic stall_bad = 1'b0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tx_ring_seq #(.RING(RING), .POLL_CYC(POLL), .MAX_FRAMES(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_owned_i(rx_owned), .rx_req_o(rx_req), .rx_ack_i(rx_ack),
    .rd_req_o(rd_req), .rd_idx_o(rd_idx), .rd_ack_i(rd_ack), .rd_own_i(rd_own),
    .rd_stp_i(rd_stp), .rd_enp_i(rd_enp), .fetch_req_o(fetch_req), .fetch_idx_o(fetch_idx),
    .fetch_ack_i(fetch_ack), .fetch_last_i(fetch_last), .tx_err_i(tx_err), .tx_done_i(tx_done),
    .wb_valid_o(wb_valid), .wb_ready_i(wb_ready), .wb_idx_o(wb_idx), .wb_word_o(wb_word),
    .wb_data_o(wb_data), .int_en_i(int_en), .tint_mask_i(tmask), .tint_clr_i(tclr),
    .tint_o(tint), .irq_o(irq)
  );

  task automatic log_ev(int k, int i, int w, int d);
    if (n_ev < LOGN) begin
      ev_k[n_ev] = k; ev_i[n_ev] = i; ev_w[n_ev] = w; ev_d[n_ev] = d; ev_c[n_ev] = cyc;
      n_ev++;
    end
  endtask

  // kinds: 0 read, 1 write, 2 fetch beat, 3 rx poll
  always @(negedge clk) begin
    rd_ack = 1'b0; rx_ack = 1'b0; fetch_ack = 1'b0; fetch_last = 1'b0;
    tx_err = 1'b0; wb_ready = 1'b0;
    if (rst_n) begin
      if (rd_req) begin
        rd_ack = 1'b1;
        rd_own = (set_gen[rd_idx] != clr_gen[rd_idx]);
        rd_stp = stp_m[rd_idx];
        rd_enp = enp_m[rd_idx];
        log_ev(0, int'(rd_idx), 0, int'(rd_own));
      end
      if (rx_req) begin
        rx_ack = 1'b1;
        log_ev(3, 0, 0, 0);
      end
      if (fetch_req) begin
        if (err_used < err_req && int'(fetch_idx) == err_idx) begin
          tx_err = 1'b1;
          err_used++;
          beat = 0;
        end else begin
          fetch_ack  = 1'b1;
          fetch_last = (beat == 1);
          log_ev(2, int'(fetch_idx), 0, beat);
          beat = (beat == 1) ? 0 : 1;
        end
      end
      if (wb_valid) begin
        if (stall_used < stall_req) begin
          stall_used++;
          if (wb_idx != 3'd4) stall_bad = 1'b1;
        end else begin
          wb_ready = 1'b1;
          if (!wb_word) clr_gen[wb_idx] = set_gen[wb_idx];
          log_ev(1, int'(wb_idx), int'(wb_word), int'(wb_data));
        end
      end
    end
  end

  function automatic int find_ev(int k, int i, int w, int from);
    for (int n = from; n < n_ev; n++)
      if (n >= 0 && ev_k[n] == k && ev_i[n] == i && (w < 0 || ev_w[n] == w)) return n;
    return -1;
  endfunction

  function automatic int count_ev(int k, int i, int from);
    int c = 0;
    for (int n = from; n < n_ev; n++)
      if (ev_k[n] == k && ev_i[n] == i) c++;
    return c;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic give(int i, logic s, logic e);
    stp_m[i] = s;
    enp_m[i] = e;
    set_gen[i] = set_gen[i] + 1;
  endtask

  task automatic pulse_done(output int at);
    @(negedge clk) tx_done = 1'b1;
    at = cyc;
    @(negedge clk) tx_done = 1'b0;
  endtask

  initial begin
    #40000;
    $display("FAIL watchdog actual %0d expected 0", 1);
    $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
    $finish;
  end

  initial begin
    int rel, p, q, b2, b3, dc;
    for (int i = 0; i < RING; i++) begin
      set_gen[i] = 0; clr_gen[i] = 0; stp_m[i] = 1'b0; enp_m[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk(!rd_req && !fetch_req && !wb_valid && !rx_req, "R1 reset requests",
        int'({rd_req, fetch_req, wb_valid, rx_req}), 0);
    chk(!tint && !irq, "R1 reset tint", int'({tint, irq}), 0);
    rst_n = 1'b1;
    rel = cyc;

    // empty ring
    repeat (45) @(negedge clk);
    p = find_ev(3, 0, -1, 0);
    chk(p >= 0 && ev_c[p] - rel >= POLL - 2 && ev_c[p] - rel <= POLL + 2,
        "R1 first poll cycle", (p >= 0) ? ev_c[p] - rel : -1, POLL);
    q = find_ev(0, 0, -1, 0);
    chk(q >= 0 && p < q, "R9 rx poll before tx read", q, p + 1);
    p = find_ev(0, 0, -1, q + 1);
    chk(p > q && ev_c[p] - ev_c[q] >= POLL, "R3 re-poll gap",
        (p > q) ? ev_c[p] - ev_c[q] : -1, POLL);
    chk(count_ev(1, 0, 0) == 0 && count_ev(2, 0, 0) == 0, "R3 unowned ignored",
        count_ev(1, 0, 0) + count_ev(2, 0, 0), 0);

    // two chained frames: A = 0,1  B = 2,3
    @(negedge clk);
    b2 = n_ev;
    give(3, 1'b0, 1'b1); give(2, 1'b1, 1'b0); give(1, 1'b0, 1'b1); give(0, 1'b1, 1'b0);
    repeat (60) @(negedge clk);
    p = find_ev(1, 0, 0, b2); q = find_ev(0, 1, -1, b2);
    chk(p >= 0 && q > p && ev_d[p] == 0, "R4 release before next read", p, q);
    chk(find_ev(1, 2, 0, b2) >= 0 && count_ev(1, 1, b2) == 0, "R4 chained next frame released early",
        count_ev(1, 1, b2), 0);
    chk(count_ev(0, 4, b2) == 0, "R5 hold with two frames", count_ev(0, 4, b2), 0);
    chk(find_ev(0, 2, -1, q) > q, "R5 look-ahead past end", find_ev(0, 2, -1, q), q + 1);
    chk(count_ev(2, 3, b2) == 2, "R3 owned start fetched", count_ev(2, 3, b2), 2);
    pulse_done(dc);
    repeat (12) @(negedge clk);
    chk(find_ev(1, 1, 0, b2) >= 0, "R6 done write oldest", find_ev(1, 1, 0, b2), 0);
    p = find_ev(0, 4, -1, b2);
    chk(p >= 0 && ev_c[p] - dc <= 8, "R6 immediate poll", (p >= 0) ? ev_c[p] - dc : -1, 8);
    chk(tint == 1'b1, "R10 tint on done", int'(tint), 1);
    pulse_done(dc);
    repeat (12) @(negedge clk);
    chk(find_ev(1, 3, 0, b2) >= 0, "R6 second done write", find_ev(1, 3, 0, b2), 0);

    // interrupt gating table
    foreach (IRQ_TAB[r]) begin
      @(negedge clk);
      int_en = IRQ_TAB[r][2];
      tmask  = IRQ_TAB[r][1];
      #1;
      chk(irq == IRQ_TAB[r][0], "R10 irq gating", int'(irq), int'(IRQ_TAB[r][0]));
    end
    @(negedge clk) begin int_en = 1'b1; tmask = 1'b0; tclr = 1'b1; end
    @(negedge clk) tclr = 1'b0;
    chk(!tint && !irq, "R10 clear", int'({tint, irq}), 0);

    // error and skip: frame 4,5,6 errors at 5; frame 7 single buffer
    rx_owned = 1'b1;
    stall_req = 3;
    err_req = 1;
    @(negedge clk);
    b3 = n_ev;
    give(7, 1'b1, 1'b1); give(6, 1'b0, 1'b1); give(5, 1'b0, 1'b0); give(4, 1'b1, 1'b0);
    repeat (60) @(negedge clk);
    chk(count_ev(1, 4, b3) == 1 && !stall_bad && stall_used == 3, "R11 stalled write held",
        count_ev(1, 4, b3), 1);
    p = find_ev(1, 5, 1, b3); q = find_ev(1, 5, 0, b3);
    chk(p >= 0 && q == p + 1 && ev_d[p] == 1 && ev_d[q] == 0, "R7 error write pair", q, p + 1);
    chk(count_ev(2, 5, 0) == 0, "R7 no fetch after error", count_ev(2, 5, 0), 0);
    chk(find_ev(1, 6, 0, b3) > q && count_ev(1, 7, b3) == 0, "R8 skip chained",
        find_ev(1, 6, 0, b3), q + 1);
    p = find_ev(2, 7, -1, b3);
    chk(p > q, "R8 stop at start and fetch", p, q + 1);
    chk(find_ev(0, 0, -1, p) > p, "R2 wrap to zero", find_ev(0, 0, -1, p), p + 1);
    chk(count_ev(2, 0, b3) == 0, "R3 wrapped unowned not fetched", count_ev(2, 0, b3), 0);
    chk(count_ev(3, 0, b3) == 0, "R9 rx owned no poll", count_ev(3, 0, b3), 0);
    chk(tint == 1'b1, "R10 tint on error", int'(tint), 1);
    pulse_done(dc);
    repeat (12) @(negedge clk);
    chk(find_ev(1, 7, 0, b3) >= 0, "R6 done after skip", find_ev(1, 7, 0, b3), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule